// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block drives and samples up to 32 general-purpose pads behind a simple 32-bit register bus with byte addresses and word-aligned registers. For each pin, software controls whether the input is sampled, whether the pad is driven, the value driven, and an inversion mask applied on the way to the pad. Pad inputs are brought into the clock domain through a synchroniser chain before anything else looks at them.

Each pin watches four conditions on its synchronised input: a rising edge, a falling edge, a high level and a low level. Every condition has its own pending register and its own enable register. Pending bits latch on their condition and hold until software writes a 1 to them. A pin raises its own interrupt line while any pending condition has its enable set. The usual pattern is to enable one condition, wait for the pin's line, then clear the pending bit by writing 1 to it.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, `pad_oe`, `pad_out` and `pin_irq` are all zero. The input-enable, output-enable, output-value, inversion and all four condition-enable registers read as zero.
- R2: The output-value register (byte offset 0x0C) reads back the value last written to it, whatever the pads are doing.
- R3: `pad_out` equals the output-value register XORed bit by bit with the inversion register (offset 0x40). `pad_oe` equals the output-enable register (offset 0x08) and changes only when that register is written.
- R4: Pads pass through a two-stage synchroniser. A read of offset 0x00 returns the synchronised pad value ANDed with the input-enable register (offset 0x04), so a pin with its input enable clear reads 0.
- R5: A rising-edge pending bit (offset 0x1C) sets when the synchronised input goes 0 to 1. A falling-edge pending bit (offset 0x24) sets when it goes 1 to 0. The current synchronised value is compared with the value from the cycle before.
- R6: The high-level pending bit (offset 0x2C) and the low-level pending bit (offset 0x34) set on every cycle in which that level is present on the synchronised input.
- R7: Pending bits are sticky. Once set, a bit stays set after its condition goes away, until software clears it.
- R8: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R9: If hardware sets a pending bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R10: `pin_irq[n]` is high while any of pin n's pending bits is set together with its enable bit. The enables for rise, fall, high and low are at offsets 0x18, 0x20, 0x28 and 0x30. A pad change reaches `pin_irq` on the third rising clock edge after the change.
- R11: Read data appears on `bus_rdata` on the clock edge after the read request. Unmapped offsets read 0. Writes to the input-value offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Bus access request, valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS | Raw pad inputs |
| pad_out | output | NPINS | Pad output values after inversion |
| pad_oe | output | NPINS | Pad drive enables, 0 = tri-stated |
| pin_irq | output | NPINS | Per-pin interrupt lines |

## Verification
A wrong synchroniser depth or a wrong edge-history register shows up as a `pin_irq` that rises one edge early or one edge late. It can also show up as a rise or fall pending bit that sets on a steady level. The bench checks the third-edge latency exactly. A broken clear path or set-priority rule is visible on the next register read: a sticky bit drops out, a written 0 clears a bit, or a low-level bit reads clear even though the pad is held low. A faulty output path shows on `pad_out` or `pad_oe` at the first negative edge after the write.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int ADDR_W = 7;
    localparam int BUS_W  = 32;
    localparam int NCOND  = 4;

    typedef logic [ADDR_W-1:0] gaddr_t;

    localparam gaddr_t OFF_IN_VAL    = 7'h00;
    localparam gaddr_t OFF_IN_EN     = 7'h04;
    localparam gaddr_t OFF_OUT_EN    = 7'h08;
    localparam gaddr_t OFF_OUT_VAL   = 7'h0C;
    localparam gaddr_t OFF_COND_BASE = 7'h18;
    localparam gaddr_t OFF_OUT_XOR   = 7'h40;

    // condition index k: enable at base + 8k, pending at base + 8k + 4
    typedef enum logic [1:0] {
        COND_RISE = 2'd0,
        COND_FALL = 2'd1,
        COND_HIGH = 2'd2,
        COND_LOW  = 2'd3
    } cond_e;

    function automatic gaddr_t cond_en_off(input int k);
        return OFF_COND_BASE + gaddr_t'(8 * k);
    endfunction

    function automatic gaddr_t cond_pend_off(input int k);
        return OFF_COND_BASE + gaddr_t'(8 * k + 4);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
            prev_o <= '0;
        end else begin
            stage_q[0] <= pad_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            prev_o <= stage_q[STAGES-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank
    import gpio_pin_pkg::*;
#(
    parameter int    W    = 32,
    parameter cond_e KIND = COND_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] req_o
);

    generate
        if (KIND == COND_RISE) begin : g_rise
            assign event_o = sync_i & ~prev_i;
        end else if (KIND == COND_FALL) begin : g_fall
            assign event_o = ~sync_i & prev_i;
        end else if (KIND == COND_HIGH) begin : g_high
            assign event_o = sync_i;
        end else begin : g_low
            assign event_o = ~sync_i;
        end
    endgenerate

    // a set arriving with a clear keeps the bit
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~clr_i) | event_o;
        end
    end

    assign req_o = pend_o & en_i;

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pin_irq
);

    logic             wr_hit;
    logic [NPINS-1:0] wdat;
    logic [NPINS-1:0] in_en_q, out_en_q, out_val_q, out_xor_q;
    logic [NPINS-1:0] cond_en_q [NCOND];
    logic [NPINS-1:0] sync_v, prev_v;
    logic [NPINS-1:0] clr_v  [NCOND];
    logic [NPINS-1:0] ev_v   [NCOND];
    logic [NPINS-1:0] pend_v [NCOND];
    logic [NPINS-1:0] req_v  [NCOND];
    logic [NPINS-1:0] rd_mux;
    logic [NPINS-1:0] rise_ev, pend_rise;

    assign wr_hit = bus_req & bus_wr;
    assign wdat   = bus_wdata[NPINS-1:0];

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_i  (pad_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    generate
        for (genvar k = 0; k < NCOND; k++) begin : g_cond
            assign clr_v[k] = (wr_hit && bus_addr == cond_pend_off(k)) ? wdat : '0;

            gpio_pend_bank #(.W(NPINS), .KIND(cond_e'(k))) u_bank (
                .clk     (clk),
                .rst     (rst),
                .sync_i  (sync_v),
                .prev_i  (prev_v),
                .clr_i   (clr_v[k]),
                .en_i    (cond_en_q[k]),
                .event_o (ev_v[k]),
                .pend_o  (pend_v[k]),
                .req_o   (req_v[k])
            );
        end
    endgenerate

    assign rise_ev   = ev_v[0];
    assign pend_rise = pend_v[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            in_en_q   <= '0;
            out_en_q  <= '0;
            out_val_q <= '0;
            out_xor_q <= '0;
            for (int k = 0; k < NCOND; k++) begin
                cond_en_q[k] <= '0;
            end
        end else if (wr_hit) begin
            if (bus_addr == OFF_IN_EN)   in_en_q   <= wdat;
            if (bus_addr == OFF_OUT_EN)  out_en_q  <= wdat;
            if (bus_addr == OFF_OUT_VAL) out_val_q <= wdat;
            if (bus_addr == OFF_OUT_XOR) out_xor_q <= wdat;
            for (int k = 0; k < NCOND; k++) begin
                if (bus_addr == cond_en_off(k)) cond_en_q[k] <= wdat;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_IN_VAL:  rd_mux = sync_v & in_en_q;
            OFF_IN_EN:   rd_mux = in_en_q;
            OFF_OUT_EN:  rd_mux = out_en_q;
            OFF_OUT_VAL: rd_mux = out_val_q;
            OFF_OUT_XOR: rd_mux = out_xor_q;
            default:     rd_mux = '0;
        endcase
        for (int k = 0; k < NCOND; k++) begin
            if (bus_addr == cond_en_off(k))   rd_mux = cond_en_q[k];
            if (bus_addr == cond_pend_off(k)) rd_mux = pend_v[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_req && !bus_wr) begin
            bus_rdata <= BUS_W'(rd_mux);
        end
    end

    always_comb begin
        pin_irq = '0;
        for (int k = 0; k < NCOND; k++) begin
            pin_irq = pin_irq | req_v[k];
        end
    end

    assign pad_out = out_val_q ^ out_xor_q;
    assign pad_oe  = out_en_q;

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_pin_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  rise_ev,
    input logic [NPINS-1:0]  pend_rise
);

    function automatic logic is_mapped(input gaddr_t a);
        return (a == OFF_IN_VAL) || (a == OFF_IN_EN) || (a == OFF_OUT_EN) ||
               (a == OFF_OUT_VAL) || (a == OFF_OUT_XOR) ||
               (a >= OFF_COND_BASE && a <= cond_pend_off(NCOND - 1) && a[1:0] == 2'b00);
    endfunction

    logic rise_clr_wr;
    assign rise_clr_wr = bus_req && bus_wr && (bus_addr == cond_pend_off(0));

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rise_clr_wr |=> ((pend_rise & $past(pend_rise)) == $past(pend_rise))); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rise_clr_wr |=> ((pend_rise & $past(bus_wdata[NPINS-1:0]) & ~$past(rise_ev)) == '0)); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rise_ev) & ~pend_rise) == '0)); // R9

    AST_RISE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_rise & ~$past(pend_rise)) & ~$past(rise_ev)) == '0)); // R5

    AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_wr && bus_addr == OFF_OUT_EN) |=> $stable(pad_oe)); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wr && !is_mapped(bus_addr)) |=> (bus_rdata == '0)); // R11

endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .rise_ev   (rise_ev),
    .pend_rise (pend_rise)
);

// File: tb/test_gpio_pin_ctrl.sv
module test_gpio_pin_ctrl;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0;
    logic          bus_wr = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pin_irq;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    logic rd_v = 1'b0;

    always #5 clk = ~clk;

    gpio_pin_ctrl #(.NPINS(NP)) i_gpio_pin_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pin_irq   (pin_irq)
    );

    // monitor: a read issued at one edge shows data at the next negedge
    always @(posedge clk) rd_v <= bus_req && !bus_wr && !rst;

    always @(negedge clk) begin : mon
        exp_t e;
        if (rd_v) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %h expected none", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        e.exp = exp; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1 reset state
        chk(pad_oe, 32'h0, "R1 pad_oe");
        chk(pad_out, 32'h0, "R1 pad_out");
        chk(pin_irq, 32'h0, "R1 pin_irq");
        rd(7'h04, 32'h0, "R1 in_en");
        rd(7'h08, 32'h0, "R1 out_en");
        rd(7'h0C, 32'h0, "R1 out_val");
        rd(7'h40, 32'h0, "R1 xor");
        rd(7'h18, 32'h0, "R1 rise_en");
        rd(7'h30, 32'h0, "R1 low_en");

        // R2 / R3 output path
        wr(7'h0C, 32'hA5A5_0F0F);
        chk(pad_out, 32'hA5A5_0F0F, "R3 pad_out plain");
        pad_in = 32'h0000_1234;
        rd(7'h0C, 32'hA5A5_0F0F, "R2 out_val readback");
        wr(7'h40, 32'hFFFF_0000);
        chk(pad_out, 32'h5A5A_0F0F, "R3 pad_out inverted");
        rd(7'h0C, 32'hA5A5_0F0F, "R2 out_val unaffected by xor");
        rd(7'h40, 32'hFFFF_0000, "R3 xor readback");
        wr(7'h08, 32'h0000_FFFF);
        chk(pad_oe, 32'h0000_FFFF, "R3 pad_oe");

        // R4 input path gated by input enable
        pad_in = 32'h00F0_F00F;
        idle(4);
        rd(7'h00, 32'h0, "R4 input disabled");
        wr(7'h04, 32'hFFFF_FFFF);
        rd(7'h00, 32'h00F0_F00F, "R4 input enabled");
        wr(7'h04, 32'h0000_FFFF);
        rd(7'h00, 32'h0000_F00F, "R4 partial enable");
        // R11 ignored write, unmapped read
        wr(7'h00, 32'hFFFF_FFFF);
        rd(7'h00, 32'h0000_F00F, "R11 write to input value ignored");
        rd(7'h10, 32'h0, "R11 unmapped offset");

        // R5..R9 pending behaviour
        pad_in = '0;
        idle(5);
        wr(7'h1C, 32'hFFFF_FFFF);
        wr(7'h24, 32'hFFFF_FFFF);
        wr(7'h2C, 32'hFFFF_FFFF);
        rd(7'h1C, 32'h0, "R8 rise cleared");
        rd(7'h24, 32'h0, "R8 fall cleared");
        rd(7'h2C, 32'h0, "R8 high cleared");
        pad_in = 32'h0000_0001;
        idle(5);
        rd(7'h1C, 32'h1, "R5 rise pending");
        rd(7'h24, 32'h0, "R5 no fall on rise");
        rd(7'h2C, 32'h1, "R6 high pending");
        pad_in = '0;
        idle(5);
        rd(7'h24, 32'h1, "R5 fall pending");
        rd(7'h1C, 32'h1, "R7 rise sticky");
        rd(7'h2C, 32'h1, "R7 high sticky");
        wr(7'h2C, 32'h1);
        rd(7'h2C, 32'h0, "R8 high w1c");
        wr(7'h1C, 32'h0);
        rd(7'h1C, 32'h1, "R8 zero write keeps bit");
        rd(7'h34, 32'hFFFF_FFFF, "R6 low pending all pins");
        wr(7'h34, 32'h1);
        rd(7'h34, 32'hFFFF_FFFF, "R9 set wins over clear");

        // R10 interrupt lines
        chk(pin_irq, 32'h0, "R10 no enables");
        wr(7'h18, 32'h1);
        chk(pin_irq, 32'h1, "R10 rise enabled");
        wr(7'h18, 32'h0);
        wr(7'h30, 32'h6);
        chk(pin_irq, 32'h6, "R10 low enabled");
        pad_in = 32'h6;
        idle(5);
        wr(7'h34, 32'h6);
        chk(pin_irq, 32'h0, "R10 cleared drops line");
        @(negedge clk);
        pad_in = '0;
        idle(2);
        chk(pin_irq, 32'h0, "R10 not yet after two edges");
        idle(1);
        chk(pin_irq, 32'h6, "R10 asserted on third edge");

        idle(3);
        if (sbq.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL scoreboard leftover: got %0d expected 0", sbq.size());
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule